// File: doc/BRIEF.md
# Scale-Space Extremum Detector

This block decides whether the middle sample of a 3x3x3 cube of signed difference-of-Gaussian values is a strict local peak or a strict local trough. The cube covers three adjacent blur scales: the scale under test and the scales on either side of it. Each of the 26 surrounding samples feeds its own comparator lane. Each lane produces a two-bit relation code. A reduction stage folds the codes into a candidate flag and a polarity flag. The x, y and scale coordinates presented with the cube travel alongside it to the output.

An upstream window generator presents one cube per cycle, qualified by `valid_i`. The block is a two-stage pipeline: the first stage compares and the second stage reduces. It accepts a new cube on every cycle. Downstream stages handle sub-pixel refinement, contrast rejection and edge rejection.

Top module: `ssx_extremum_detect`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first accepted cube has passed through, `valid_o`, `cand_o` and `is_max_o` are 0.
- R2: `valid_o` is high exactly two rising edges after a rising edge at which `valid_i` was high, and is low otherwise.
- R3: When `valid_o` is high, `x_o`, `y_o` and `scale_o` equal the `x_i`, `y_i` and `scale_i` presented with that cube.
- R4: If the centre is strictly greater than all 26 neighbours, the result has `cand_o`=1 and `is_max_o`=1.
- R5: If the centre is strictly less than all 26 neighbours, the result has `cand_o`=1 and `is_max_o`=0.
- R6: If any neighbour equals the centre, `cand_o`=0 for that cube.
- R7: Samples are compared as signed two's complement; for example, 16'h7FFF is greater than 16'h8000.
- R8: `cube_i` holds 27 samples of `DATA_W` bits. Sample j sits at bits [j*DATA_W +: DATA_W], where j = 9*s + 3*r + c. s=0 is the lower scale, s=1 is the current scale and s=2 is the upper scale. The centre is j=13, and each of the 26 other positions counts towards the decision. Internally, each lane reports 2'b01 when the centre is greater, 2'b10 when it is less, and 2'b00 when the two are equal.
- R9: When `valid_o` is low, `cand_o` and `is_max_o` are 0. `is_max_o` is never 1 while `cand_o` is 0.
- R10: Cubes presented on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Cube and coordinates are valid this cycle |
| cube_i | input | 27*DATA_W | Packed 3x3x3 sample cube |
| x_i | input | X_W | Column of the centre sample |
| y_i | input | Y_W | Row of the centre sample |
| scale_i | input | S_W | Scale index of the centre sample |
| valid_o | output | 1 | Result valid |
| cand_o | output | 1 | Centre is a strict extremum |
| is_max_o | output | 1 | Extremum is a maximum (0: minimum) |
| x_o | output | X_W | Column carried with the result |
| y_o | output | Y_W | Row carried with the result |
| scale_o | output | S_W | Scale carried with the result |

## Verification
A lane wired to the wrong cube slot, or a reduction that skips one lane, becomes visible only when that particular neighbour is the sole one breaking or tying the extremum. The bench therefore sweeps a single spoiling neighbour through all 26 positions and checks each result two cycles after the cube goes in. A stale relation register or coordinate register shows up on the very next result when cubes are streamed back to back. An unsigned comparison reverses the polarity of cubes whose samples straddle zero or the ends of the signed range.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_GT = 2'b01,
    REL_LT = 2'b10
  } rel_e;

  localparam int unsigned CUBE_N  = 27;
  localparam int unsigned NBR_N   = CUBE_N - 1;
  localparam int unsigned CTR_IDX = CUBE_N / 2;

  // neighbour lane k -> cube slot, skipping the centre
  function automatic int unsigned nbr_slot(int unsigned k);
    return (k < CTR_IDX) ? k : k + 1;
  endfunction
endpackage

// File: rtl/ssx_cmp_lane.sv
module ssx_cmp_lane
  import ssx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] ctr_i,
  input  logic signed [DATA_W-1:0] nbr_i,
  output rel_e                     rel_o
);
  always_comb begin
    if (ctr_i > nbr_i)      rel_o = REL_GT;
    else if (ctr_i < nbr_i) rel_o = REL_LT;
    else                    rel_o = REL_EQ;
  end
endmodule

// File: rtl/ssx_cmp_stage.sv
module ssx_cmp_stage
  import ssx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRD_W  = 28
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [CUBE_N*DATA_W-1:0]   cube_i,
  input  logic [CRD_W-1:0]           crd_i,
  output logic                       valid_o,
  output logic [NBR_N-1:0][1:0]      rel_o,
  output logic [CRD_W-1:0]           crd_o
);
  logic signed [DATA_W-1:0] ctr;
  logic [NBR_N-1:0][1:0]    rel_d;

  assign ctr = cube_i[CTR_IDX*DATA_W +: DATA_W];

  for (genvar k = 0; k < NBR_N; k++) begin : g_lane
    localparam int unsigned SLOT = nbr_slot(k);
    rel_e lane_rel;
    ssx_cmp_lane #(.DATA_W(DATA_W)) u_lane (
      .ctr_i (ctr),
      .nbr_i (cube_i[SLOT*DATA_W +: DATA_W]),
      .rel_o (lane_rel)
    );
    assign rel_d[k] = lane_rel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_o <= '0;
      crd_o <= '0;
    end else if (valid_i) begin
      rel_o <= rel_d;
      crd_o <= crd_i;
    end
  end
endmodule

// File: rtl/ssx_reduce_stage.sv
module ssx_reduce_stage
  import ssx_pkg::*;
#(
  parameter int unsigned CRD_W = 28
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [NBR_N-1:0][1:0] rel_i,
  input  logic [CRD_W-1:0]      crd_i,
  output logic                  valid_o,
  output logic                  cand_o,
  output logic                  is_max_o,
  output logic [CRD_W-1:0]      crd_o
);
  logic all_gt, all_lt;

  always_comb begin
    all_gt = 1'b1;
    all_lt = 1'b1;
    for (int k = 0; k < NBR_N; k++) begin
      if (rel_i[k] != REL_GT) all_gt = 1'b0;
      if (rel_i[k] != REL_LT) all_lt = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      cand_o   <= 1'b0;
      is_max_o <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      cand_o   <= valid_i & (all_gt | all_lt);
      is_max_o <= valid_i & all_gt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crd_o <= '0;
    else if (valid_i) crd_o <= crd_i;
  end
endmodule

// File: rtl/ssx_extremum_detect.sv
module ssx_extremum_detect
  import ssx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned X_W    = 12,
  parameter int unsigned Y_W    = 12,
  parameter int unsigned S_W    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [CUBE_N*DATA_W-1:0] cube_i,
  input  logic [X_W-1:0]           x_i,
  input  logic [Y_W-1:0]           y_i,
  input  logic [S_W-1:0]           scale_i,
  output logic                     valid_o,
  output logic                     cand_o,
  output logic                     is_max_o,
  output logic [X_W-1:0]           x_o,
  output logic [Y_W-1:0]           y_o,
  output logic [S_W-1:0]           scale_o
);
  localparam int unsigned CRD_W = X_W + Y_W + S_W;

  logic                  s1_valid;
  logic [NBR_N-1:0][1:0] s1_rel;
  logic [CRD_W-1:0]      s1_crd;
  logic [CRD_W-1:0]      s2_crd;

  ssx_cmp_stage #(.DATA_W(DATA_W), .CRD_W(CRD_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .cube_i  (cube_i),
    .crd_i   ({x_i, y_i, scale_i}),
    .valid_o (s1_valid),
    .rel_o   (s1_rel),
    .crd_o   (s1_crd)
  );

  ssx_reduce_stage #(.CRD_W(CRD_W)) u_red (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .rel_i    (s1_rel),
    .crd_i    (s1_crd),
    .valid_o  (valid_o),
    .cand_o   (cand_o),
    .is_max_o (is_max_o),
    .crd_o    (s2_crd)
  );

  assign {x_o, y_o, scale_o} = s2_crd;
endmodule

// File: rtl/ssx_extremum_sva.sv
module ssx_extremum_sva #(
  parameter int unsigned X_W = 12,
  parameter int unsigned Y_W = 12,
  parameter int unsigned S_W = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [X_W-1:0] x_i,
  input logic [Y_W-1:0] y_i,
  input logic [S_W-1:0] scale_i,
  input logic           valid_o,
  input logic           cand_o,
  input logic           is_max_o,
  input logic [X_W-1:0] x_o,
  input logic [Y_W-1:0] y_o,
  input logic [S_W-1:0] scale_o
);
  localparam int unsigned CRD_W = X_W + Y_W + S_W;

  logic             v_d1, v_d2;
  logic [CRD_W-1:0] c_d1, c_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_d1 <= 1'b0; v_d2 <= 1'b0;
      c_d1 <= '0;   c_d2 <= '0;
    end else begin
      v_d1 <= valid_i; v_d2 <= v_d1;
      c_d1 <= {x_i, y_i, scale_i}; c_d2 <= c_d1;
    end
  end

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_d2);

  a_r3_coord_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({x_o, y_o, scale_o} == c_d2));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!cand_o && !is_max_o));

  a_r9_max_needs_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_max_o |-> cand_o);

  a_r10_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d1 && v_d2) |=> valid_o);
endmodule

bind ssx_extremum_detect ssx_extremum_sva #(
  .X_W(X_W), .Y_W(Y_W), .S_W(S_W)
) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .x_i      (x_i),
  .y_i      (y_i),
  .scale_i  (scale_i),
  .valid_o  (valid_o),
  .cand_o   (cand_o),
  .is_max_o (is_max_o),
  .x_o      (x_o),
  .y_o      (y_o),
  .scale_o  (scale_o)
);

// File: tb/ssx_extremum_detect_test.sv
module ssx_extremum_detect_test;
  localparam int DW = 16, XW = 12, YW = 12, SW = 4;
  localparam int CW = XW + YW + SW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, valid_i;
  logic [27*DW-1:0] cube_i;
  logic [XW-1:0]    x_i, x_o;
  logic [YW-1:0]    y_i, y_o;
  logic [SW-1:0]    scale_i, scale_o;
  logic             valid_o, cand_o, is_max_o;

  ssx_extremum_detect #(.DATA_W(DW), .X_W(XW), .Y_W(YW), .S_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .cube_i(cube_i),
    .x_i(x_i), .y_i(y_i), .scale_i(scale_i),
    .valid_o(valid_o), .cand_o(cand_o), .is_max_o(is_max_o),
    .x_o(x_o), .y_o(y_o), .scale_o(scale_o)
  );

  int n_cmp = 0, n_bad = 0;
  logic signed [DW-1:0] cb [27];

  logic e1_v = 0, e2_v = 0, e1_c = 0, e2_c = 0, e1_m = 0, e2_m = 0;
  logic [CW-1:0] e1_crd = '0, e2_crd = '0;
  string e1_tag = "", e2_tag = "";

  task automatic check(string tag, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_eval();
    logic gt = 1'b1, lt = 1'b1;
    for (int k = 0; k < 27; k++) begin
      if (k != 13) begin
        if (!(cb[13] > cb[k])) gt = 1'b0;
        if (!(cb[13] < cb[k])) lt = 1'b0;
      end
    end
    return {gt | lt, gt};
  endfunction

  task automatic step(logic v, string tag);
    logic [1:0] r;
    @(negedge clk);
    if (e2_v) begin
      check("R2", "valid_o", CW'(valid_o), CW'(1));
      check(e2_tag, "cand_o", CW'(cand_o), CW'(e2_c));
      check(e2_tag, "is_max_o", CW'(is_max_o), CW'(e2_m));
      check("R3", "coords", {x_o, y_o, scale_o}, e2_crd);
    end else begin
      check("R2", "valid_o idle", CW'(valid_o), CW'(0));
      check("R9", "cand/max idle", CW'({cand_o, is_max_o}), CW'(0));
    end
    e2_v = e1_v; e2_c = e1_c; e2_m = e1_m; e2_crd = e1_crd; e2_tag = e1_tag;
    for (int k = 0; k < 27; k++) cube_i[k*DW +: DW] = cb[k];
    x_i = XW'($urandom); y_i = YW'($urandom); scale_i = SW'($urandom);
    valid_i = v;
    r = ref_eval();
    e1_v = v; e1_c = r[1]; e1_m = r[0]; e1_crd = {x_i, y_i, scale_i}; e1_tag = tag;
  endtask

  task automatic fill_max(int c);
    for (int k = 0; k < 27; k++) cb[k] = DW'(c - 1 - int'($urandom % 500));
    cb[13] = DW'(c);
  endtask

  task automatic fill_min(int c);
    for (int k = 0; k < 27; k++) cb[k] = DW'(c + 1 + int'($urandom % 500));
    cb[13] = DW'(c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; cube_i = '0; x_i = '0; y_i = '0; scale_i = '0;
    for (int k = 0; k < 27; k++) cb[k] = '0;
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", CW'({valid_o, cand_o, is_max_o}), CW'(0));
    rst_n = 1'b1;
    step(1'b0, "R1");
    step(1'b0, "R1");
    check("R1", "outputs after reset", CW'({valid_o, cand_o, is_max_o}), CW'(0));

    // R4 / R5 basic extrema
    fill_max(1000);  step(1'b1, "R4");
    fill_min(-1000); step(1'b1, "R5");
    step(1'b0, "R9");

    // R7 signed ordering
    for (int k = 0; k < 27; k++) cb[k] = 16'hFFFF;
    cb[13] = 16'h0000; step(1'b1, "R7");
    for (int k = 0; k < 27; k++) cb[k] = 16'h8000;
    cb[13] = 16'h7FFF; step(1'b1, "R7");
    for (int k = 0; k < 27; k++) cb[k] = 16'h7FFF;
    cb[13] = 16'h8000; step(1'b1, "R7");

    // R8 / R6 spoil each neighbour position in turn, streamed back to back (R10)
    for (int p = 0; p < 27; p++) begin
      if (p != 13) begin
        fill_max(200); cb[p] = DW'(200);  step(1'b1, "R6");
        fill_max(200); cb[p] = DW'(201);  step(1'b1, "R8");
        fill_min(-200); cb[p] = DW'(-200); step(1'b1, "R6");
        fill_min(-200); cb[p] = DW'(-201); step(1'b1, "R8");
      end
    end

    // random cubes over a narrow range, forced extrema, idle gaps
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < 27; k++) begin
        int t;
        t = int'($urandom % 5) - 2;
        cb[k] = t[DW-1:0];
      end
      if (i % 4 == 1) cb[13] = DW'(3);
      if (i % 4 == 3) cb[13] = DW'(-3);
      step((i % 7) != 5, "R10");
    end

    step(1'b0, "R9");
    step(1'b0, "R9");
    step(1'b0, "R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule